// File: doc/BRIEF.md
# Programmable Management Clock Divider

This block derives the serial management clock used to talk to Ethernet PHYs from the system clock. Software writes a 6-bit divisor N through a 32-bit control word. When N is zero the management clock is off and sits low. When N is non-zero the clock runs at the system clock rate divided by 2N, high for N cycles and low for N cycles. A 50 MHz system clock with N = 10 gives 2.5 MHz, which is the fastest rate a management interface allows.

Alongside the clock the block produces a one-cycle strobe for each rising edge and each falling edge, so a downstream serial shifter can move data without detecting edges itself. A divisor change takes effect only at a clock edge. The half-period in progress always completes with the value it started with, so the output never produces a runt pulse. Clearing the divisor while the clock is high lets the high phase finish, and the clock then falls and stays low. A frame-start request is acknowledged only while the divisor is non-zero.

Top module: `mdc_clkgen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the clock output, both strobes and the acknowledge are low, and the control word reads back as zero.
- R2: The divisor is held in bits 6 to 1 of the control word. Every other bit, bit 0 included, reads back as zero whatever value was written to it.
- R3: While the divisor is zero and the clock is low, the clock stays low and no strobe is raised.
- R4: When a non-zero N is written while the clock is stopped, the first rising edge appears exactly N system clocks after the clock edge that captured the write.
- R5: While N is unchanged, every high phase and every low phase lasts exactly N system clocks.
- R6: The rise strobe is high for exactly the one cycle in which the clock output first reads high. The fall strobe is high for exactly the one cycle in which it first reads low. Neither strobe is raised at any other time.
- R7: A non-zero divisor written during a half-period does not shorten or lengthen that half-period. The half-periods that follow use the new value.
- R8: A zero divisor written while the clock is high lets the high phase complete with the old length. The clock then falls once and stays low.
- R9: A zero divisor written while the clock is low stops the clock without producing another rising edge.
- R10: A frame request sampled while the stored divisor is non-zero raises the acknowledge for exactly the following cycle.
- R11: A frame request sampled while the stored divisor is zero raises no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we_i | input | 1 | Write enable for the control word |
| ctrl_wdata_i | input | 32 | Control word write data; divisor in bits 6:1 |
| ctrl_rdata_o | output | 32 | Control word readback |
| frame_req_i | input | 1 | Request to start a management frame |
| frame_ack_o | output | 1 | One-cycle pulse when a request is accepted |
| mdc_o | output | 1 | Management clock output |
| mdc_rise_o | output | 1 | Strobe in the cycle the clock goes high |
| mdc_fall_o | output | 1 | Strobe in the cycle the clock goes low |

## Verification
The bench sweeps every divisor from 1 to 10 and measures the start latency and both phase widths. A counter that reloads off by one would show up there as a period of 2N±2, and a divisor of 1 that could not toggle would stall. It rewrites the divisor in the middle of high phases and low phases. A design that applied the new value at once would cut a phase short or stretch it. Clearing the divisor in each phase catches a clock that freezes high or emits one more rising edge. Frame requests made with the divisor zero and with it non-zero expose an acknowledge that ignores the divisor. The strobes are compared with the clock transitions on every sampled cycle.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
    localparam int MDC_DIV_W   = 6;
    localparam int MDC_DIV_LSB = 1;
    localparam int MDC_CTRL_W  = 32;

    typedef struct packed {
        logic rise;
        logic fall;
    } mdc_edge_t;
endpackage

// File: rtl/mdc_divreg.sv
module mdc_divreg #(
    parameter int DIV_W   = mdc_pkg::MDC_DIV_W,
    parameter int DIV_LSB = mdc_pkg::MDC_DIV_LSB,
    parameter int CTRL_W  = mdc_pkg::MDC_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [DIV_W-1:0]  div_next_o,
    output logic [CTRL_W-1:0] rdata_o
);
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            r_d.div = wdata_i[DIV_MSB:DIV_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_o      = r_q.div;
    assign div_next_o = r_d.div;

    always_comb begin
        rdata_o                  = '0;
        rdata_o[DIV_MSB:DIV_LSB] = r_q.div;
    end
endmodule

// File: rtl/mdc_halfcnt.sv
module mdc_halfcnt #(
    parameter int DIV_W = mdc_pkg::MDC_DIV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    div_next_i,
    output logic                mdc_o,
    output mdc_pkg::mdc_edge_t  edge_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic             run;
        logic             mdc;
        logic             rise;
        logic             fall;
        logic [DIV_W-1:0] cnt;
    } hc_t;

    hc_t s_d, s_q;
    logic div_nz;

    assign div_nz = (div_next_i != '0);

    always_comb begin
        s_d      = s_q;
        s_d.rise = 1'b0;
        s_d.fall = 1'b0;
        if (!s_q.run) begin
            s_d.mdc = 1'b0;
            if (div_nz) begin
                s_d.run = 1'b1;
                s_d.cnt = div_next_i - ONE;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - ONE;
        end else if (div_nz) begin
            s_d.mdc  = ~s_q.mdc;
            s_d.rise = ~s_q.mdc;
            s_d.fall = s_q.mdc;
            s_d.cnt  = div_next_i - ONE;
        end else begin
            s_d.run  = 1'b0;
            s_d.cnt  = '0;
            s_d.mdc  = 1'b0;
            s_d.fall = s_q.mdc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc_o       = s_q.mdc;
    assign edge_o.rise = s_q.rise;
    assign edge_o.fall = s_q.fall;
endmodule

// File: rtl/mdc_frame_gate.sv
module mdc_frame_gate #(
    parameter int DIV_W = mdc_pkg::MDC_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             req_i,
    output logic             ack_o
);
    typedef struct packed {
        logic ack;
    } fg_t;

    fg_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.ack = req_i && (div_i != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ack_o = g_q.ack;
endmodule

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
    parameter int DIV_W   = mdc_pkg::MDC_DIV_W,
    parameter int DIV_LSB = mdc_pkg::MDC_DIV_LSB,
    parameter int CTRL_W  = mdc_pkg::MDC_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_rdata_o,
    input  logic              frame_req_i,
    output logic              frame_ack_o,
    output logic              mdc_o,
    output logic              mdc_rise_o,
    output logic              mdc_fall_o
);
    logic [DIV_W-1:0]   div_q;
    logic [DIV_W-1:0]   div_next;
    mdc_pkg::mdc_edge_t edge_s;

    mdc_divreg #(.DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .CTRL_W(CTRL_W)) u_divreg (
        .clk       (clk),
        .rst       (rst),
        .we_i      (ctrl_we_i),
        .wdata_i   (ctrl_wdata_i),
        .div_o     (div_q),
        .div_next_o(div_next),
        .rdata_o   (ctrl_rdata_o)
    );

    mdc_halfcnt #(.DIV_W(DIV_W)) u_halfcnt (
        .clk       (clk),
        .rst       (rst),
        .div_next_i(div_next),
        .mdc_o     (mdc_o),
        .edge_o    (edge_s)
    );

    mdc_frame_gate #(.DIV_W(DIV_W)) u_gate (
        .clk  (clk),
        .rst  (rst),
        .div_i(div_q),
        .req_i(frame_req_i),
        .ack_o(frame_ack_o)
    );

    assign mdc_rise_o = edge_s.rise;
    assign mdc_fall_o = edge_s.fall;
endmodule

// File: rtl/mdc_clkgen_chk.sv
module mdc_clkgen_chk #(
    parameter int DIV_W   = mdc_pkg::MDC_DIV_W,
    parameter int DIV_LSB = mdc_pkg::MDC_DIV_LSB,
    parameter int CTRL_W  = mdc_pkg::MDC_CTRL_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl_rdata_o,
    input logic              frame_req_i,
    input logic              frame_ack_o,
    input logic              mdc_o,
    input logic              mdc_rise_o,
    input logic              mdc_fall_o
);
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    logic div_zero;
    assign div_zero = (ctrl_rdata_o[DIV_MSB:DIV_LSB] == '0);

    // R3
    a_r3_zero_stays_low: assert property (@(posedge clk) disable iff (rst)
        (div_zero && !mdc_o) |=> (!mdc_o && !mdc_rise_o));

    // R6
    a_r6_rise_on_high: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc_o) |-> (mdc_rise_o && !mdc_fall_o));
    a_r6_fall_on_low: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc_o) |-> (mdc_fall_o && !mdc_rise_o));
    a_r6_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
        $stable(mdc_o) |-> !(mdc_rise_o || mdc_fall_o));

    // R10 and R11
    a_r10_ack_needs_request: assert property (@(posedge clk) disable iff (rst)
        frame_ack_o |-> $past(frame_req_i));
    a_r11_ack_needs_divisor: assert property (@(posedge clk) disable iff (rst)
        (frame_req_i && div_zero) |=> !frame_ack_o);

    // R2
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata_o & ~({{(CTRL_W-DIV_W){1'b0}}, {DIV_W{1'b1}}} << DIV_LSB)) == '0);
endmodule

bind mdc_clkgen mdc_clkgen_chk #(.DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .CTRL_W(CTRL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctrl_rdata_o(ctrl_rdata_o),
    .frame_req_i (frame_req_i),
    .frame_ack_o (frame_ack_o),
    .mdc_o       (mdc_o),
    .mdc_rise_o  (mdc_rise_o),
    .mdc_fall_o  (mdc_fall_o)
);

// File: tb/mdc_clkgen_tb.sv
module mdc_clkgen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we_i = 1'b0;
    logic [31:0] ctrl_wdata_i = '0;
    logic [31:0] ctrl_rdata_o;
    logic        frame_req_i = 1'b0;
    logic        frame_ack_o;
    logic        mdc_o, mdc_rise_o, mdc_fall_o;

    int checks = 0;
    int failures = 0;
    logic prev_mdc = 1'b0;

    always #5 clk = ~clk;

    mdc_clkgen u_dut (
        .clk(clk), .rst(rst),
        .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
        .ctrl_rdata_o(ctrl_rdata_o),
        .frame_req_i(frame_req_i), .frame_ack_o(frame_ack_o),
        .mdc_o(mdc_o), .mdc_rise_o(mdc_rise_o), .mdc_fall_o(mdc_fall_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // one clock edge, sample 1 ns later; strobes compared with transitions (R6)
    task automatic step();
        @(posedge clk);
        #1;
        if (!rst) begin
            chk("R6 rise", mdc_rise_o, (mdc_o && !prev_mdc) ? 1 : 0);
            chk("R6 fall", mdc_fall_o, (!mdc_o && prev_mdc) ? 1 : 0);
        end
        prev_mdc = mdc_o;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        chk("R1 mdc", mdc_o, 0);
        chk("R1 rise", mdc_rise_o, 0);
        chk("R1 fall", mdc_fall_o, 0);
        chk("R1 ack", frame_ack_o, 0);
        chk("R1 rdata", ctrl_rdata_o, 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 mdc after", mdc_o, 0);
        chk("R1 rdata after", ctrl_rdata_o, 0);
    endtask

    task automatic write_div(input int n);
        ctrl_we_i    = 1'b1;
        ctrl_wdata_i = 32'(n) << 1;
        step();
        ctrl_we_i    = 1'b0;
        ctrl_wdata_i = '0;
    endtask

    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        while (mdc_o != lvl && n < 300) begin
            step();
            n++;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int highs;
        do_reset();

        // R3: idle with zero divisor
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (mdc_o) highs++;
        end
        chk("R3 idle highs", highs, 0);

        // R4, R5: sweep divisors
        for (int d = 1; d <= 10; d++) begin
            write_div(d);
            chk("R2 readback", ctrl_rdata_o, d * 2);
            wait_level(1'b1, n);
            chk("R4 first rise", n, d);
            for (int p = 0; p < 3; p++) begin
                wait_level(1'b0, n);
                chk("R5 high width", n, d);
                wait_level(1'b1, n);
                chk("R5 low width", n, d);
            end
            write_div(0);
            wait_level(1'b0, n);
            for (int i = 0; i < 2 * d + 2; i++) step();
            chk("R9 stopped", mdc_o, 0);
        end

        // R7: change during high phase 3 -> 5
        write_div(3);
        wait_level(1'b1, n);
        write_div(5);
        wait_level(1'b0, n);
        chk("R7 old high", n + 1, 3);
        wait_level(1'b1, n);
        chk("R7 new low", n, 5);
        wait_level(1'b0, n);
        chk("R7 new high", n, 5);
        // R7: change during low phase 5 -> 2
        step();
        write_div(2);
        wait_level(1'b1, n);
        chk("R7 old low", n + 2, 5);
        wait_level(1'b0, n);
        chk("R7 new high2", n, 2);

        // R8: zero while high
        write_div(4);
        wait_level(1'b1, n);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        write_div(0);
        wait_level(1'b0, n);
        chk("R8 high completes", n + 1, 4);
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (mdc_o) highs++;
        end
        chk("R8 stays low", highs, 0);

        // R9: zero while low
        write_div(4);
        wait_level(1'b1, n);
        wait_level(1'b0, n);
        step();
        write_div(0);
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (mdc_o) highs++;
        end
        chk("R9 no rise", highs, 0);

        // R11: request with zero divisor
        frame_req_i = 1'b1;
        step();
        chk("R11 no ack", frame_ack_o, 0);
        frame_req_i = 1'b0;
        step();
        chk("R11 no ack later", frame_ack_o, 0);

        // R10: request with non-zero divisor
        write_div(3);
        frame_req_i = 1'b1;
        step();
        chk("R10 ack", frame_ack_o, 1);
        frame_req_i = 1'b0;
        step();
        chk("R10 ack one cycle", frame_ack_o, 0);

        // R2: reserved bits
        ctrl_we_i    = 1'b1;
        ctrl_wdata_i = 32'hFFFF_FFFF;
        step();
        ctrl_we_i    = 1'b0;
        chk("R2 reserved bits", ctrl_rdata_o, 32'h0000_007E);
        ctrl_we_i    = 1'b1;
        ctrl_wdata_i = 32'h0000_0001;
        step();
        ctrl_we_i    = 1'b0;
        chk("R2 bit0 ignored", ctrl_rdata_o, 0);

        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule